// File: doc/BRIEF.md
# Low-Address Protection and Prefix Mapper

This block sits on the access path of a processor core after address translation. For each access it does two things. It decides whether the access touches the protected low storage area. It also converts the real address into an absolute address through a relocatable prefix.

Protection covers two small windows at the start of the first two 4 KiB pages. Whether protection applies depends on three things: a control enable bit, whether address translation is on, and the private-space bit of the selected address space. A store that falls inside a window while protection is active raises a fault. Any access to either of the two low pages while protection is active raises a hint that the translation must not be cached for writes.

Prefixing swaps the first 8 KiB of real storage with the 8 KiB area at the prefix, and the swap works in both directions. Software loads the prefix through a one-cycle write port. Results are registered and appear one cycle after the request.

Top module: `lowprot_prefix_unit`

## Requirements
- R1: An address is in a protected window when it lies in 0..511 or in 4096..4607. A store (req_kind = 1) to such an address, with protection active, sets prot_fault. Addresses 512..4095 and 4608 and above never fault.
- R2: When prot_en is 0, prot_fault and wr_inval_hint stay 0 for every address, kind and selector.
- R3: When prot_en is 1 and dat_on is 0, protection is active whatever space_sel and priv_bits hold.
- R4: When prot_en is 1 and dat_on is 1, protection is active only if the private-space bit of the selected space is 0. The selectors are space_sel 0 = primary (priv_bits[0]), 2 = secondary (priv_bits[1]) and 3 = home (priv_bits[2]).
- R5: space_sel = 1 with dat_on = 1 sets mode_err. In that case prot_fault and wr_inval_hint stay 0 and abs_addr is 0.
- R6: With protection active, any access whose address lies in 0..8191 (page 0 or page 1) sets wr_inval_hint, whatever its kind or whether the byte is inside a window.
- R7: Loads (kind 0) and fetches (kind 2) never fault. A faulting access returns abs_addr = 0.
- R8: A non-faulting real address below 0x2000 maps to that address plus the prefix.
- R9: An address in [prefix, prefix + 0x2000) that is not below 0x2000 maps to that address minus the prefix. Every other address passes unchanged.
- R10: The prefix resets to 0. A write with pfx_we stores pfx_wdata with its low 13 bits cleared. The new value applies only to requests presented in later cycles.
- R11: Each request with req_valid produces exactly one result with rsp_valid one clock later. Outputs are 0 when rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Real address of the access |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| prot_en | input | 1 | Low-address protection enable |
| dat_on | input | 1 | Address translation mode active |
| space_sel | input | 2 | Address-space selector: 0 primary, 1 access-register, 2 secondary, 3 home |
| priv_bits | input | 3 | Private-space bits of the primary, secondary and home control words |
| pfx_we | input | 1 | Prefix register write strobe |
| pfx_wdata | input | ADDR_W | Prefix write value |
| rsp_valid | output | 1 | Result valid |
| abs_addr | output | ADDR_W | Absolute address |
| prot_fault | output | 1 | Protection fault (exception code zero) |
| wr_inval_hint | output | 1 | Do not cache writes for this page |
| mode_err | output | 1 | Unsupported address-space mode |

## Verification
The stimulus walks the addresses on both sides of every window edge (511/512, 4095/4096, 4607/4608, 8191/8192) with stores and loads. This separates the byte-window check from the page hint. The enable is then crossed with the translation bit, each selector and each private bit, so a wrong choice of control-word bit shows as a missing or extra fault. After a non-zero prefix is loaded, addresses in the low area, in the prefix area, just past it and far away tell the two swap directions apart from the pass-through case. A request issued in the same cycle as a prefix write shows whether the old prefix is still applied to it.

// File: rtl/lpp_pkg.sv
// Shared encodings for the low-address protection and prefix mapper.
package lpp_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'd0,
        SP_ACCREG    = 2'd1,
        SP_SECONDARY = 2'd2,
        SP_HOME      = 2'd3
    } space_sel_e;

    localparam int NUM_SPACES = 3;
endpackage

// File: rtl/lap_window_chk.sv
// Window classifier: reports whether an address is in one of the first two
// pages and whether it falls in the protected head of such a page.
// Assumes WIN_BYTES is a power of two no larger than the page size.
module lap_window_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int WIN_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_low_page,
    output logic              in_window
);
    localparam int WIN_BITS = $clog2(WIN_BYTES);

    // Pages 0 and 1 share all address bits above the page-pair boundary as zero.
    always_comb begin
        in_low_page = (addr[ADDR_W-1:PAGE_BITS+1] == '0);
        in_window   = in_low_page && (addr[PAGE_BITS-1:WIN_BITS] == '0);
    end
endmodule

// File: rtl/lap_enable_sel.sv
// Protection enable selector: combines the enable bit, translation mode and
// the private-space bit of the chosen address space. Flags the
// access-register selector as unsupported when translation is on.
module lap_enable_sel
    import lpp_pkg::*;
(
    input  logic                  prot_en,
    input  logic                  dat_on,
    input  logic [1:0]            space_sel,
    input  logic [NUM_SPACES-1:0] priv_bits,
    output logic                  active,
    output logic                  mode_err
);
    space_sel_e sel;
    logic       priv_sel;

    // Pick the private-space bit belonging to the selected space.
    always_comb begin
        sel      = space_sel_e'(space_sel);
        priv_sel = 1'b0;
        mode_err = 1'b0;
        unique case (sel)
            SP_PRIMARY:   priv_sel = priv_bits[0];
            SP_SECONDARY: priv_sel = priv_bits[1];
            SP_HOME:      priv_sel = priv_bits[2];
            SP_ACCREG:    mode_err = dat_on;
            default:      priv_sel = 1'b0;
        endcase
    end

    // Without translation protection depends only on the enable bit.
    always_comb begin
        if (!prot_en || mode_err) begin
            active = 1'b0;
        end else if (!dat_on) begin
            active = 1'b1;
        end else begin
            active = !priv_sel;
        end
    end
endmodule

// File: rtl/prefix_swap.sv
// Prefix mapper: swaps the low area of real storage with the area at the
// prefix. Assumes the prefix has its low AREA_BITS bits zero.
module prefix_swap #(
    parameter int ADDR_W    = 32,
    parameter int AREA_BITS = 13
) (
    input  logic [ADDR_W-1:0] real_addr,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] abs_addr
);
    logic in_low_area;
    logic in_pfx_area;

    // The low-area test wins, so a zero prefix maps the low area onto itself.
    always_comb begin
        in_low_area = (real_addr[ADDR_W-1:AREA_BITS] == '0);
        in_pfx_area = (real_addr[ADDR_W-1:AREA_BITS] == prefix[ADDR_W-1:AREA_BITS]);
        if (in_low_area) begin
            abs_addr = real_addr + prefix;
        end else if (in_pfx_area) begin
            abs_addr = real_addr - prefix;
        end else begin
            abs_addr = real_addr;
        end
    end
endmodule

// File: rtl/lowprot_prefix_unit.sv
// Low-address protection checker and prefix mapper. Holds the prefix
// register, classifies each request and registers the result for one cycle.
// Assumes the request inputs are stable for the cycle in which req_valid is high.
module lowprot_prefix_unit
    import lpp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int WIN_BYTES = 512,
    parameter int AREA_BITS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_kind,
    input  logic                  prot_en,
    input  logic                  dat_on,
    input  logic [1:0]            space_sel,
    input  logic [NUM_SPACES-1:0] priv_bits,
    input  logic                  pfx_we,
    input  logic [ADDR_W-1:0]     pfx_wdata,
    output logic                  rsp_valid,
    output logic [ADDR_W-1:0]     abs_addr,
    output logic                  prot_fault,
    output logic                  wr_inval_hint,
    output logic                  mode_err
);
    localparam logic [ADDR_W-1:0] PFX_MASK = {{(ADDR_W-AREA_BITS){1'b1}}, {AREA_BITS{1'b0}}};

    logic [ADDR_W-1:0] prefix_q;
    logic              in_low_page, in_window;
    logic              prot_active, sel_err;
    logic [ADDR_W-1:0] mapped;
    logic              fault_d, hint_d;
    logic [ADDR_W-1:0] abs_d;

    // Prefix register, aligned on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix_q <= '0;
        end else if (pfx_we) begin
            prefix_q <= pfx_wdata & PFX_MASK;
        end
    end

    lap_window_chk #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_BYTES(WIN_BYTES)
    ) u_win (
        .addr(req_addr), .in_low_page(in_low_page), .in_window(in_window)
    );

    lap_enable_sel u_en (
        .prot_en(prot_en), .dat_on(dat_on), .space_sel(space_sel),
        .priv_bits(priv_bits), .active(prot_active), .mode_err(sel_err)
    );

    prefix_swap #(
        .ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS)
    ) u_swap (
        .real_addr(req_addr), .prefix(prefix_q), .abs_addr(mapped)
    );

    // Combine classification into fault, hint and address.
    always_comb begin
        fault_d = prot_active && in_window && (acc_kind_e'(req_kind) == ACC_STORE);
        hint_d  = prot_active && in_low_page;
        abs_d   = (fault_d || sel_err) ? '0 : mapped;
    end

    // Output register: one result per request, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            abs_addr      <= '0;
            prot_fault    <= 1'b0;
            wr_inval_hint <= 1'b0;
            mode_err      <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            abs_addr      <= req_valid ? abs_d : '0;
            prot_fault    <= req_valid && fault_d;
            wr_inval_hint <= req_valid && hint_d;
            mode_err      <= req_valid && sel_err;
        end
    end
endmodule

// File: rtl/lpp_checker.sv
// Property checker for lowprot_prefix_unit, attached by bind below.
module lpp_checker #(
    parameter int ADDR_W    = 32,
    parameter int AREA_BITS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              prot_en,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] abs_addr,
    input logic              prot_fault,
    input logic              wr_inval_hint,
    input logic              mode_err,
    input logic [ADDR_W-1:0] prefix_q
);
    // R7: only stores fault, and only on a valid result
    p_store_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (rsp_valid && $past(req_kind) == 2'd1));

    // R7: faulting access returns a zero address
    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (abs_addr == '0));

    // R6: a protected byte always lies in a hinted page
    p_fault_hint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> wr_inval_hint);

    // R2: disabled protection is silent
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(prot_en)) |-> (!prot_fault && !wr_inval_hint));

    // R5: unsupported mode gives no fault, no hint, zero address
    p_moderr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!prot_fault && !wr_inval_hint && abs_addr == '0));

    // R11: each request yields a result next cycle
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: prefix stays aligned
    p_pfx_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prefix_q[AREA_BITS-1:0] == '0);
endmodule

bind lowprot_prefix_unit lpp_checker #(
    .ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS)
) u_lpp_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .prot_en(prot_en), .rsp_valid(rsp_valid), .abs_addr(abs_addr),
    .prot_fault(prot_fault), .wr_inval_hint(wr_inval_hint),
    .mode_err(mode_err), .prefix_q(prefix_q)
);

// File: tb/tb_lowprot_prefix_unit.sv
// Scoreboard bench: the driver pushes expected results, a monitor pops them.
module tb_lowprot_prefix_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_kind;
    logic          prot_en, dat_on;
    logic [1:0]    space_sel;
    logic [2:0]    priv_bits;
    logic          pfx_we;
    logic [AW-1:0] pfx_wdata;
    logic          rsp_valid;
    logic [AW-1:0] abs_addr;
    logic          prot_fault, wr_inval_hint, mode_err;

    int checks   = 0;
    int failures = 0;
    longint model_pfx = 0;

    logic [AW-1:0] q_addr[$];
    logic [2:0]    q_flags[$];
    string         q_tag[$];

    always #4 clk = ~clk;

    lowprot_prefix_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .prot_en(prot_en), .dat_on(dat_on),
        .space_sel(space_sel), .priv_bits(priv_bits), .pfx_we(pfx_we),
        .pfx_wdata(pfx_wdata), .rsp_valid(rsp_valid), .abs_addr(abs_addr),
        .prot_fault(prot_fault), .wr_inval_hint(wr_inval_hint), .mode_err(mode_err)
    );

    function automatic longint map_addr(longint a);
        if (a < 64'h2000) return a + model_pfx;
        if (a >= model_pfx && a < model_pfx + 64'h2000) return a - model_pfx;
        return a;
    endfunction

    // Drive one request, optionally with a prefix write in the same cycle.
    task automatic drive(input longint a, input int kind, input bit en, input bit dat,
                         input int sel, input int priv, input string tag,
                         input bit pw = 1'b0, input longint pv = 0);
        bit merr, act, pv_bit, win, lowpg, flt, hnt;
        longint ex;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a[AW-1:0]; req_kind = kind[1:0];
        prot_en = en; dat_on = dat; space_sel = sel[1:0]; priv_bits = priv[2:0];
        pfx_we = pw; pfx_wdata = pv[AW-1:0];
        merr   = dat && (sel == 1);
        pv_bit = (sel == 0) ? priv[0] : (sel == 2) ? priv[1] : priv[2];
        act    = en && !merr && (!dat || !pv_bit);
        lowpg  = a < 8192;
        win    = (a <= 511) || (a >= 4096 && a <= 4607);
        hnt    = act && lowpg;
        flt    = act && win && (kind == 1);
        ex     = (flt || merr) ? 0 : map_addr(a);
        q_addr.push_back(ex[AW-1:0]);
        q_flags.push_back({flt, hnt, merr});
        q_tag.push_back(tag);
        if (pw) model_pfx = pv & ~64'h1FFF;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; pfx_we = 1'b0;
    endtask

    // Monitor: compare each result against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (rst_n && rsp_valid) begin
            checks++;
            if (q_addr.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected result: actual rsp_valid=1 expected 0");
            end else begin
                logic [AW-1:0] ea;
                logic [2:0]    ef;
                string         t;
                ea = q_addr.pop_front(); ef = q_flags.pop_front(); t = q_tag.pop_front();
                if (abs_addr !== ea || {prot_fault, wr_inval_hint, mode_err} !== ef) begin
                    failures++;
                    $display("FAIL %s: actual addr=%h f/h/m=%b expected addr=%h f/h/m=%b",
                             t, abs_addr, {prot_fault, wr_inval_hint, mode_err}, ea, ef);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = 2'd0;
        prot_en = 1'b0; dat_on = 1'b0; space_sel = 2'd0; priv_bits = 3'd0;
        pfx_we = 1'b0; pfx_wdata = '0;
        repeat (3) @(posedge clk);
        #2;
        checks++;  // R11 reset state
        if (rsp_valid !== 1'b0 || prot_fault !== 1'b0 || abs_addr !== '0) begin
            failures++;
            $display("FAIL R11 reset: actual v=%b f=%b a=%h expected 0/0/0", rsp_valid, prot_fault, abs_addr);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 window edges with stores, translation off (R3)
        drive(0,    1, 1, 0, 0, 7, "R1 store@0");
        drive(511,  1, 1, 0, 0, 7, "R1 store@511");
        drive(512,  1, 1, 0, 0, 7, "R1 store@512");
        drive(4095, 1, 1, 0, 0, 7, "R1 store@4095");
        drive(4096, 1, 1, 0, 0, 7, "R3 store@4096");
        drive(4607, 1, 1, 0, 0, 7, "R1 store@4607");
        drive(4608, 1, 1, 0, 0, 7, "R6 store@4608");
        drive(8191, 1, 1, 0, 0, 7, "R6 store@8191");
        drive(8192, 1, 1, 0, 0, 7, "R6 store@8192");
        // R7 loads and fetches never fault
        drive(0,   0, 1, 0, 0, 0, "R7 load@0");
        drive(100, 2, 1, 0, 0, 0, "R7 fetch@100");
        // R2 disabled
        drive(0,    1, 0, 0, 0, 0, "R2 store@0 off");
        drive(4100, 1, 0, 1, 2, 0, "R2 store@4100 off dat");
        // R4 selectors and private bits
        drive(10, 1, 1, 1, 0, 3'b110, "R4 primary clear");
        drive(10, 1, 1, 1, 0, 3'b001, "R4 primary set");
        drive(10, 1, 1, 1, 2, 3'b101, "R4 secondary clear");
        drive(10, 1, 1, 1, 2, 3'b010, "R4 secondary set");
        drive(10, 1, 1, 1, 3, 3'b011, "R4 home clear");
        drive(10, 1, 1, 1, 3, 3'b100, "R4 home set");
        // R5 access-register selector
        drive(10,      1, 1, 1, 1, 0, "R5 accreg dat");
        drive(32'h5000, 0, 0, 1, 1, 0, "R5 accreg far");
        drive(10,      1, 1, 0, 1, 0, "R3 accreg no dat");
        // R10 prefix write in the same cycle as a request: old prefix (zero) applies
        drive(32'h100, 0, 0, 0, 0, 0, "R10 same-cycle old pfx", 1'b1, 64'h0001_3FFF);
        // R8 low area relocated
        drive(32'h100,  0, 0, 0, 0, 0, "R8 low->pfx");
        drive(32'h1FFF, 0, 0, 0, 0, 0, "R8 low top");
        // R9 prefix area and pass-through
        drive(32'h12345, 0, 0, 0, 0, 0, "R9 pfx->low");
        drive(32'h13FFF, 0, 0, 0, 0, 0, "R9 pfx top");
        drive(32'h14000, 0, 0, 0, 0, 0, "R9 past pfx");
        drive(32'h11FFF, 0, 0, 0, 0, 0, "R9 below pfx");
        drive(32'h8000_0000, 2, 1, 0, 0, 0, "R9 far");
        // R8 protected store still faults with prefix loaded
        drive(4096, 1, 1, 0, 0, 0, "R7 fault zero addr");
        drive(4700, 0, 1, 0, 0, 0, "R8 hint with pfx");
        idle();
        repeat (3) @(negedge clk);
        checks++;  // R11 every request answered
        if (q_addr.size() != 0) begin
            failures++;
            $display("FAIL R11 pending: actual %0d expected 0", q_addr.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule